// File: doc/BRIEF.md
# Watchdog Timer with Early Warning Interrupt

This block is a memory-mapped watchdog. Software programs a timeout, starts the countdown with a code written to a control register, and refreshes the count from time to time. A prescaler divides the system clock into a coarse 128 ms unit, and the down-counter steps once per unit. If software stops refreshing, the block first raises a non-maskable interrupt a fixed lead time ahead of expiry. Once the count is used up, it drives a reset pulse of fixed length, meant to cut power to the whole machine.

The register port is a simple 16-bit bus: a select, a write strobe, a byte address, write data and combinational read data. The reload register sits at byte offset 0x70 and the control register at 0x72. Bit 0 of the control register enables counting. The usual start code is 0x85. Stopping is a read-modify-write that clears bit 0. A timeout of T seconds is loaded as (T*1000)/128 units, so the 30 s to 600 s range needs counts of 234 to 4687. These fit the 16-bit reload register.

Top module: `wdog_nmi_timer`

## Requirements
- R1: After reset, nmi_o and sys_rst_o are low and both the reload register (offset 0x70) and the control register (offset 0x72) read 0.
- R2: The reload register at 0x70 and the control register at 0x72 read back the last value written. Any other offset reads 0, and writes to it change neither register.
- R3: Writing the control register with bit 0 set while bit 0 was clear (start code 0x85) loads the counter from the reload register and clears the prescaler. The counter then drops by one every CLK_KHZ*UNIT_MS clock cycles.
- R4: With a loaded count N of 1 or more, sys_rst_o rises exactly N units after the start write and stays high for RST_PULSE cycles. Control bit 0 is then clear, so 0x85 reads back as 0x84, and the counter stays stopped.
- R5: nmi_o rises on the unit step that leaves LEAD_MS/UNIT_MS units or fewer remaining. If the loaded count is already within that window, it rises on the first step. It stays high until a reset or a counter load.
- R6: Writing the reload register while running reloads the counter with the written value, restarts the prescaler and drops nmi_o. Expiry is pushed to a full N units after that write.
- R7: Clearing control bit 0 halts the countdown and asserts neither output. A later start reloads the count from the reload register, not from the halted value.
- R8: Writing the reload register while stopped only stores the value. Counting does not start and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| nmi_o | output | 1 | Early warning interrupt, sticky level |
| sys_rst_o | output | 1 | Reset / power-removal pulse |

## Verification
The bench builds the block with CLK_KHZ=1 and UNIT_MS=128, so one count unit is 128 clock cycles instead of 12.8 million. LEAD_MS=1024 gives a warning window of 8 units, and RST_PULSE=4. Under these values a full countdown of 12 units, including the warning edge, the expiry edge and the end of the pulse, takes under two thousand cycles. That lets the bench check each edge to the exact cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 16;
  localparam int RUN_BIT = 0;

  // Ticks in one unit of the coarse time base.
  function automatic int unit_cycles(input int clk_khz, input int unit_ms);
    return clk_khz * unit_ms;
  endfunction

  // Warning window, in units.
  function automatic int lead_units(input int lead_ms, input int unit_ms);
    return lead_ms / unit_ms;
  endfunction

  // Remaining count after one unit step, saturating at zero.
  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // True when a remaining count lies inside the warning window.
  function automatic logic in_window(input logic [DATA_W-1:0] c, input int lead);
    return int'({16'b0, c}) <= lead;
  endfunction
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RELOAD_OFS = 'h70,
  parameter int CTRL_OFS = 'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] reload_q,
  output logic              run_q,
  output logic              start_pulse,
  output logic              refresh_pulse
);
  logic [DATA_W-1:0] ctrl_q;
  logic hit_reload, hit_ctrl, wr_reload, wr_ctrl;

  assign hit_reload = (bus_addr == ADDR_W'(RELOAD_OFS));
  assign hit_ctrl   = (bus_addr == ADDR_W'(CTRL_OFS));
  assign wr_reload  = bus_sel && bus_wr && hit_reload;
  assign wr_ctrl    = bus_sel && bus_wr && hit_ctrl;

  assign run_q         = ctrl_q[RUN_BIT];
  assign start_pulse   = wr_ctrl && bus_wdata[RUN_BIT] && !ctrl_q[RUN_BIT];
  assign refresh_pulse = wr_reload && ctrl_q[RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (expire) ctrl_q[RUN_BIT] <= 1'b0;
    end
  end

  always_comb begin
    if (hit_reload) bus_rdata = reload_q;
    else if (hit_ctrl) bus_rdata = ctrl_q;
    else bus_rdata = '0;
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_CYCLES - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int LEAD_TICKS = 70,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire,
  output logic              nmi_o,
  output logic              sys_rst_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] pulse_q;
  logic [DATA_W-1:0] next_cnt;
  logic step;

  assign step     = run && tick && !load;
  assign next_cnt = step_down(cnt_q);
  assign expire   = step && (cnt_q <= 16'd1);
  assign sys_rst_o = (pulse_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      nmi_o   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (load) begin
        cnt_q <= load_val;
        nmi_o <= 1'b0;
      end else if (step) begin
        cnt_q <= next_cnt;
        if (in_window(next_cnt, LEAD_TICKS)) nmi_o <= 1'b1;
      end
      if (expire) pulse_q <= PW'(RST_PULSE);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_nmi_timer.sv
module wdog_nmi_timer
  import wdog_pkg::*;
#(
  parameter int CLK_KHZ = 100_000,
  parameter int UNIT_MS = 128,
  parameter int LEAD_MS = 9000,
  parameter int RST_PULSE = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              nmi_o,
  output logic              sys_rst_o
);
  localparam int TICK_CYCLES = unit_cycles(CLK_KHZ, UNIT_MS);
  localparam int LEAD_TICKS  = lead_units(LEAD_MS, UNIT_MS);

  logic [DATA_W-1:0] reload_q, cnt_q, load_val;
  logic run_q, start_pulse, refresh_pulse, cnt_load, tick, expire;

  assign cnt_load = start_pulse || refresh_pulse;
  assign load_val = start_pulse ? reload_q : bus_wdata;

  wdog_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
    .bus_rdata(bus_rdata), .reload_q(reload_q), .run_q(run_q),
    .start_pulse(start_pulse), .refresh_pulse(refresh_pulse)
  );

  wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(cnt_load), .tick(tick)
  );

  wdog_countdown #(.LEAD_TICKS(LEAD_TICKS), .RST_PULSE(RST_PULSE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .load(cnt_load),
    .load_val(load_val), .cnt_q(cnt_q), .expire(expire), .nmi_o(nmi_o),
    .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/wdog_nmi_timer_chk.sv
module wdog_nmi_timer_chk #(
  parameter int LEAD_TICKS = 70
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        tick,
  input logic        load,
  input logic        refresh,
  input logic [15:0] load_val,
  input logic [15:0] cnt,
  input logic        nmi_o,
  input logic        sys_rst_o
);
  // R4: a reset pulse only starts on a unit step that used up the count
  a_r4_rst_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(run && tick && !load && cnt <= 16'd1));

  // R4: counting is disabled once the pulse starts
  a_r4_stopped_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> !run);

  // R3: each unit step removes exactly one from the count
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && cnt > 16'd1) |=> cnt == $past(cnt) - 16'd1);

  // R7: a stopped counter holds its value
  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  // R5: the warning stays up until a load
  a_r5_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !load) |=> nmi_o);

  // R5: the warning rises only on a step that enters the window
  a_r5_nmi_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> ($past(tick) && int'({16'b0, cnt}) <= LEAD_TICKS));

  // R6: a refresh reloads the written value and drops the warning
  a_r6_refresh_loads: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (cnt == $past(load_val) && !nmi_o));
endmodule

bind wdog_nmi_timer wdog_nmi_timer_chk #(.LEAD_TICKS(LEAD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .load(cnt_load),
  .refresh(refresh_pulse), .load_val(load_val), .cnt(cnt_q),
  .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
);

// File: tb/wdog_nmi_timer_bench.sv
module wdog_nmi_timer_bench;
  localparam int UNIT = 128;   // CLK_KHZ=1 * UNIT_MS=128
  localparam int LEAD = 8;     // 1024 / 128
  localparam int PULSE = 4;
  localparam logic [7:0] A_RELOAD = 8'h70;
  localparam logic [7:0] A_CTRL = 8'h72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic nmi_o, sys_rst_o;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  wdog_nmi_timer #(.CLK_KHZ(1), .UNIT_MS(128), .LEAD_MS(1024),
                   .RST_PULSE(PULSE), .ADDR_W(8)) u_wdog_nmi_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic skip(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    skip(3);
    rst_n = 1'b1;
    skip(1);
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    do_reset();
    chk("R1 nmi", 32'(nmi_o), 0);
    chk("R1 rst", 32'(sys_rst_o), 0);
    bus_read(A_RELOAD, d); chk("R1 reload", 32'(d), 0);
    bus_read(A_CTRL, d);   chk("R1 ctrl", 32'(d), 0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    do_reset();
    bus_write(A_RELOAD, 16'h1234);
    bus_write(A_CTRL, 16'h00A4);
    bus_write(8'h74, 16'hFFFF);
    bus_write(8'h71, 16'hBEEF);
    bus_read(A_RELOAD, d); chk("R2 reload readback", 32'(d), 32'h1234);
    bus_read(A_CTRL, d);   chk("R2 ctrl readback", 32'(d), 32'h00A4);
    bus_read(8'h74, d);    chk("R2 unmapped reads 0", 32'(d), 0);
    skip(400);
    chk("R2 no start from bit0 clear", 32'(nmi_o | sys_rst_o), 0);
  endtask

  task automatic t_expire();
    logic [15:0] d;
    do_reset();
    bus_write(A_RELOAD, 16'd12);
    bus_write(A_CTRL, 16'h0085);
    skip(UNIT * 4 - 1); chk("R5 nmi before window", 32'(nmi_o), 0);
    skip(1);            chk("R5 nmi at window", 32'(nmi_o), 1);
    chk("R3 no early rst", 32'(sys_rst_o), 0);
    skip(UNIT * 8 - 1); chk("R4 rst before expiry", 32'(sys_rst_o), 0);
    skip(1);            chk("R4 rst at expiry", 32'(sys_rst_o), 1);
    skip(PULSE - 1);    chk("R4 rst last pulse cycle", 32'(sys_rst_o), 1);
    skip(1);            chk("R4 rst pulse ended", 32'(sys_rst_o), 0);
    bus_read(A_CTRL, d); chk("R4 run bit cleared", 32'(d), 32'h0084);
    skip(UNIT * 3);
    chk("R4 no second pulse", 32'(sys_rst_o), 0);
    chk("R5 nmi sticky", 32'(nmi_o), 1);
  endtask

  task automatic t_refresh();
    do_reset();
    bus_write(A_RELOAD, 16'd12);
    bus_write(A_CTRL, 16'h0085);
    skip(600);
    chk("R5 nmi up before refresh", 32'(nmi_o), 1);
    bus_write(A_RELOAD, 16'd12);
    chk("R6 nmi dropped by refresh", 32'(nmi_o), 0);
    skip(UNIT * 4 - 1); chk("R6 nmi window restarted", 32'(nmi_o), 0);
    skip(1);            chk("R6 nmi after refresh window", 32'(nmi_o), 1);
    skip(UNIT * 8 - 1); chk("R6 expiry postponed", 32'(sys_rst_o), 0);
    skip(1);            chk("R6 expiry after refresh", 32'(sys_rst_o), 1);
  endtask

  task automatic t_stop_restart();
    logic [15:0] d;
    do_reset();
    bus_write(A_RELOAD, 16'd12);
    bus_write(A_CTRL, 16'h0085);
    skip(300);
    bus_read(A_CTRL, d);
    chk("R7 ctrl while running", 32'(d), 32'h0085);
    bus_write(A_CTRL, d & 16'h00FE);
    skip(3000);
    chk("R7 no rst while stopped", 32'(sys_rst_o), 0);
    chk("R7 no nmi while stopped", 32'(nmi_o), 0);
    bus_write(A_CTRL, 16'h0085);
    skip(UNIT * 4 - 1); chk("R7 restart reloads (nmi)", 32'(nmi_o), 0);
    skip(1);            chk("R7 restart nmi edge", 32'(nmi_o), 1);
    skip(UNIT * 8 - 1); chk("R7 restart no early rst", 32'(sys_rst_o), 0);
    skip(1);            chk("R7 restart rst edge", 32'(sys_rst_o), 1);
  endtask

  task automatic t_short_load();
    do_reset();
    bus_write(A_RELOAD, 16'd5);
    bus_write(A_CTRL, 16'h0085);
    skip(UNIT - 1); chk("R5 short load before first step", 32'(nmi_o), 0);
    skip(1);        chk("R5 short load nmi on first step", 32'(nmi_o), 1);
    skip(UNIT * 4 - 1); chk("R3 five units not yet", 32'(sys_rst_o), 0);
    skip(1);            chk("R3 five units expiry", 32'(sys_rst_o), 1);
  endtask

  task automatic t_stopped_reload();
    logic [15:0] d;
    do_reset();
    bus_write(A_RELOAD, 16'd3);
    skip(2000);
    chk("R8 no rst", 32'(sys_rst_o), 0);
    chk("R8 no nmi", 32'(nmi_o), 0);
    bus_read(A_CTRL, d);   chk("R8 ctrl still 0", 32'(d), 0);
    bus_read(A_RELOAD, d); chk("R8 value stored", 32'(d), 3);
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_readback();
    t_expire();
    t_refresh();
    t_stop_restart();
    t_short_load();
    t_stopped_reload();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule